// File: doc/BRIEF.md
# Lead-Lag Timing Loop Filter

This block is the second-order filter of a symbol timing recovery loop. Each time a timing error sample arrives, the sample is weighted by a lag gain and added to an integrator, the lag accumulator. The integrator is then clamped into a programmable window. The clamped integrator plus the same error weighted by a lead gain forms a signed 32-bit frequency word. That word steers the oscillator that sets the baseband sample rate.

Gains are held as a 4-bit mantissa and a 5-bit exponent. Two gain sets are stored, one for acquisition and one for tracking. The active set is chosen either by a control bit or by an external lock indication. A freeze input zeroes the error so the loop holds its present frequency. Software can preset the integrator through a register write, and its value is always visible on a readback port.

Top module: `timing_loop_filter`

## Requirements
- R1: After reset, `freq_out`, `freq_valid` and `lag_acc` are zero. The upper limit is 0x7FFFFFFF, the lower limit is 0x80000000, and all gain and control registers are zero.
- R2: A gain with mantissa M and exponent E weights an error x as p = x + ((x*M) >>> 4), then p >>> (32-E), using arithmetic (floor) shifts. In a gain word, the lag mantissa is bits [3:0], the lag exponent bits [8:4], the lead mantissa bits [19:16] and the lead exponent bits [24:20].
- R3: On each cycle with `err_valid` high and no preload write, the lag accumulator adds the lag-weighted error. In any other cycle without a preload write, the accumulator does not change and `freq_valid` stays low.
- R4: If the accumulator sum is above the upper limit (address 2), the accumulator is loaded with the upper limit. If it is below the lower limit (address 3), it is loaded with the lower limit. Limits are signed 32-bit.
- R5: One clock after an accepted error, `freq_valid` pulses for one cycle. In that cycle, `freq_out` equals the updated accumulator plus the lead-weighted error, saturated to the signed 32-bit range.
- R6: Address 0 holds the acquisition gain word and address 1 the tracking gain word. When control bit 0 (address 5) is 1, the tracking set is used while `lock_in` is high and the acquisition set otherwise. When control bit 0 is 0, control bit 1 selects tracking (1) or acquisition (0).
- R7: While `freeze` is high, an accepted error is treated as zero. The accumulator then only re-clamps, and `freq_out` equals the accumulator.
- R8: A write to address 4 loads the write data into the accumulator on the next clock. A preload takes precedence over a same-cycle error, which is then dropped without a `freq_valid` pulse. `lag_acc` always shows the accumulator.
- R9: Register writes take effect from the clock after the write, so an error in the same cycle uses the previous settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_in | input | EW (16) | Signed timing error |
| err_valid | input | 1 | Error strobe |
| lock_in | input | 1 | Lock indication for automatic gain selection |
| freeze | input | 1 | Nulls the error input |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 32 | Register write data |
| freq_out | output | 32 | Signed frequency control word |
| freq_valid | output | 1 | Frequency word strobe |
| lag_acc | output | 32 | Lag accumulator readback |

## Verification
The accumulator, `freq_out` and `freq_valid` are all registered once behind the error strobe, so every result is due exactly one clock after the strobe edge. The bench drives inputs on falling edges and samples on the next falling edge, half a period after the edge that produces the result. Register and preload writes are likewise checked one edge later. The bench also confirms that idle cycles leave the accumulator unchanged and raise no strobe.

// File: rtl/timing_loop_filter.sv
module timing_loop_filter #(
  parameter int EW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [EW-1:0] err_in,
  input  logic                 err_valid,
  input  logic                 lock_in,
  input  logic                 freeze,
  input  logic                 cfg_we,
  input  logic [2:0]           cfg_addr,
  input  logic [31:0]          cfg_wdata,
  output logic signed [31:0]   freq_out,
  output logic                 freq_valid,
  output logic signed [31:0]   lag_acc
);
  localparam int XW = 40;
  localparam logic signed [XW-1:0] SMAX = XW'(64'sh7FFFFFFF);
  localparam logic signed [XW-1:0] SMIN = -XW'(64'sh80000000);

  logic [31:0]        gain_acq, gain_trk, ctrl;
  logic signed [31:0] lim_hi, lim_lo;

  function automatic logic signed [XW-1:0] gscale(input logic signed [EW-1:0] v,
                                                  input logic [3:0] m, input logic [4:0] e);
    logic signed [XW-1:0] x, mm, p;
    x  = {{(XW-EW){v[EW-1]}}, v};
    mm = {{(XW-4){1'b0}}, m};
    p  = x + ((x * mm) >>> 4);
    return p >>> (6'd32 - {1'b0, e});
  endfunction

  wire                 preload = cfg_we && cfg_addr == 3'd4;
  wire                 use_trk = ctrl[0] ? lock_in : ctrl[1];
  wire [31:0]          gain    = use_trk ? gain_trk : gain_acq;
  wire signed [EW-1:0] err_eff = freeze ? '0 : err_in;

  wire signed [XW-1:0] lag_term  = gscale(err_eff, gain[3:0], gain[8:4]);
  wire signed [XW-1:0] lead_term = gscale(err_eff, gain[19:16], gain[24:20]);
  wire signed [XW-1:0] acc_sum   = {{(XW-32){lag_acc[31]}}, lag_acc} + lag_term;
  wire signed [XW-1:0] hi_x      = {{(XW-32){lim_hi[31]}}, lim_hi};
  wire signed [XW-1:0] lo_x      = {{(XW-32){lim_lo[31]}}, lim_lo};

  logic signed [XW-1:0] acc_lim, out_sum;
  always_comb begin
    if (acc_sum > hi_x)      acc_lim = hi_x;
    else if (acc_sum < lo_x) acc_lim = lo_x;
    else                     acc_lim = acc_sum;
    out_sum = acc_lim + lead_term;
  end

  wire signed [31:0] out_sat = (out_sum > SMAX) ? 32'sh7FFFFFFF :
                               (out_sum < SMIN) ? 32'sh80000000 : out_sum[31:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gain_acq <= '0;
      gain_trk <= '0;
      ctrl     <= '0;
      lim_hi   <= 32'sh7FFFFFFF;
      lim_lo   <= 32'sh80000000;
    end else if (cfg_we) begin
      case (cfg_addr)
        3'd0: gain_acq <= cfg_wdata;
        3'd1: gain_trk <= cfg_wdata;
        3'd2: lim_hi   <= cfg_wdata;
        3'd3: lim_lo   <= cfg_wdata;
        3'd5: ctrl     <= cfg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lag_acc    <= '0;
      freq_out   <= '0;
      freq_valid <= 1'b0;
    end else begin
      freq_valid <= err_valid && !preload;
      if (preload) begin
        lag_acc <= cfg_wdata;
      end else if (err_valid) begin
        lag_acc  <= acc_lim[31:0];
        freq_out <= out_sat;
      end
    end
  end

  assert_preload_R8: assert property (@(posedge clk) disable iff (!rst_n)
    preload |=> (lag_acc == $past(cfg_wdata)) && !freq_valid);

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_valid && !preload) |=> $stable(lag_acc) && !freq_valid);

  assert_in_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && !cfg_we && lim_lo <= lim_hi) |=> (lag_acc <= lim_hi) && (lag_acc >= lim_lo));

  assert_freeze_out_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && freeze && !cfg_we) |=> freq_out == lag_acc);

  assert_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && !cfg_we) |=> freq_valid);

  assert_one_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_valid && !$past(err_valid)) |-> 1'b0);
endmodule

// File: tb/timing_loop_filter_bench.sv
module timing_loop_filter_bench;
  logic clk = 0, rst_n = 0;
  logic signed [15:0] err_in = 0;
  logic err_valid = 0, lock_in = 0, freeze = 0, cfg_we = 0;
  logic [2:0] cfg_addr = 0;
  logic [31:0] cfg_wdata = 0;
  logic signed [31:0] freq_out, lag_acc;
  logic freq_valid;

  int checks = 0, errors = 0;
  longint m_acc, m_hi, m_lo;
  logic [31:0] m_acq, m_trk, m_ctrl;

  always #2 clk = ~clk;

  timing_loop_filter #(.EW(16)) u_timing_loop_filter (.*);

  function automatic longint gsc(longint x, int m, int e);
    longint p;
    p = x + ((x * m) >>> 4);
    return p >>> (32 - e);
  endfunction

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    case (a)
      3'd0: m_acq = d;
      3'd1: m_trk = d;
      3'd2: m_hi = longint'(signed'(d));
      3'd3: m_lo = longint'(signed'(d));
      3'd4: m_acc = longint'(signed'(d));
      3'd5: m_ctrl = d;
      default: ;
    endcase
    if (a == 3'd4) chk("R8 preload", lag_acc, m_acc);
  endtask

  task automatic send(logic signed [15:0] e, logic frz, logic lk, string req);
    logic [31:0] g;
    longint x, s, o;
    @(negedge clk);
    err_in = e; freeze = frz; lock_in = lk; err_valid = 1;
    g = (m_ctrl[0] ? lk : m_ctrl[1]) ? m_trk : m_acq;
    x = frz ? 0 : longint'(e);
    s = m_acc + gsc(x, int'(g[3:0]), int'(g[8:4]));
    if (s > m_hi) s = m_hi; else if (s < m_lo) s = m_lo;
    m_acc = s;
    o = s + gsc(x, int'(g[19:16]), int'(g[24:20]));
    if (o > 64'sh7FFFFFFF) o = 64'sh7FFFFFFF;
    if (o < -64'sh80000000) o = -64'sh80000000;
    @(negedge clk);
    err_valid = 0;
    chk({req, " valid"}, freq_valid, 1);
    chk({req, " out"}, freq_out, o);
    chk({req, " acc"}, lag_acc, m_acc);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_acc = 0; m_hi = 64'sh7FFFFFFF; m_lo = -64'sh80000000;
    m_acq = 0; m_trk = 0; m_ctrl = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 freq_out", freq_out, 0);
    chk("R1 valid", freq_valid, 0);
    chk("R1 acc", lag_acc, 0);

    // R2: M=5 E=31 on both lag and lead, positive and negative error
    wr(3'd0, {7'd0, 5'd31, 4'd5, 7'd0, 5'd31, 4'd5});
    send(16'sd1000, 0, 0, "R2 pos");
    chk("R2 acc 656", lag_acc, 656);
    send(-16'sd1000, 0, 0, "R2 neg");
    chk("R2 acc -1", lag_acc, -1);

    // R9: gain write in same cycle as error uses old gain
    @(negedge clk);
    cfg_we = 1; cfg_addr = 0; cfg_wdata = {7'd0, 5'd31, 4'd0, 7'd0, 5'd31, 4'd0};
    err_in = 16'sd100; err_valid = 1; freeze = 0; lock_in = 0;
    @(negedge clk);
    cfg_we = 0; err_valid = 0;
    m_acc = m_acc + gsc(100, 5, 31);
    m_acq = {7'd0, 5'd31, 4'd0, 7'd0, 5'd31, 4'd0};
    chk("R9 old gain used", lag_acc, m_acc);

    // R3: idle cycles hold
    repeat (3) @(negedge clk);
    chk("R3 idle acc", lag_acc, m_acc);
    chk("R3 idle valid", freq_valid, 0);

    // R6: track set via manual and auto
    wr(3'd1, {7'd0, 5'd30, 4'd0, 7'd0, 5'd30, 4'd0});
    wr(3'd5, 32'd2);
    send(16'sd400, 0, 0, "R6 manual track");
    wr(3'd5, 32'd1);
    send(16'sd400, 0, 1, "R6 auto lock");
    send(16'sd400, 0, 0, "R6 auto unlock");

    // R7: freeze
    send(16'sd30000, 1, 0, "R7 freeze");
    chk("R7 out equals acc", freq_out, lag_acc);

    // R4: clamp at upper then lower
    wr(3'd2, 32'd500);
    wr(3'd3, -32'sd500);
    send(16'sd30000, 0, 0, "R4 upper");
    chk("R4 at upper", lag_acc, 500);
    send(-16'sd30000, 0, 0, "R4 lower");
    chk("R4 at lower", lag_acc, -500);

    // R5: saturation of output
    wr(3'd2, 32'h7FFFFFFF);
    wr(3'd3, 32'h80000000);
    wr(3'd4, 32'h7FFFFFF0);
    wr(3'd0, {7'd0, 5'd31, 4'd15, 7'd0, 5'd0, 4'd0});
    wr(3'd5, 32'd0);
    send(16'sd32767, 0, 0, "R5 saturate");
    chk("R5 sat value", freq_out, 64'sh7FFFFFFF);

    // R8: preload beats same-cycle error
    @(negedge clk);
    cfg_we = 1; cfg_addr = 4; cfg_wdata = 32'd1234; err_in = 16'sd999; err_valid = 1;
    @(negedge clk);
    cfg_we = 0; err_valid = 0; m_acc = 1234;
    chk("R8 preload wins", lag_acc, 1234);
    chk("R8 no strobe", freq_valid, 0);

    // random phase
    for (int i = 0; i < 400; i++) begin
      int r;
      r = int'($urandom_range(0, 9));
      if (r == 0) wr(3'($urandom_range(0, 1)),
                     {7'd0, 5'($urandom_range(20, 31)), 4'($urandom),
                      7'd0, 5'($urandom_range(18, 31)), 4'($urandom)});
      else if (r == 1) begin
        int h;
        h = int'($urandom_range(0, 200000));
        wr(3'd2, 32'(h));
        wr(3'd3, 32'(-int'($urandom_range(0, 200000))));
      end else if (r == 2) wr(3'd5, 32'($urandom_range(0, 3)));
      else if (r == 3) wr(3'd4, 32'(int'($urandom_range(0, 100000)) - 50000));
      else if (r == 4) begin
        @(negedge clk);
        @(negedge clk);
        chk("R3 random idle", lag_acc, m_acc);
      end else
        send(16'($urandom), 1'($urandom_range(0, 7) == 0), 1'($urandom), "R5 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule